// File: doc/BRIEF.md
# ADC Result and Conversion Status Registers

This block keeps the conversion results and status flags of an eight-channel analog-to-digital converter with 10-bit results. A converter front end pulses one end-of-conversion event with the channel number and the result. When that channel is enabled, the block writes the result into that channel's result register and into a shared most-recent-result register. It also updates a per-channel completion flag, a per-channel overrun flag, a global data-ready flag and a global overrun flag.

Software sees these registers through a single-cycle read port. Reading a register can clear flags as a side effect. A pair of set and clear masks controls which channels may store results.

Any mix of conversion events, reads and mask writes that arrives in one clock cycle is merged into a single next state. A read or a disable that coincides with a conversion therefore never drops a data store, a flag set or a flag clear.

Top module: `adc_status_regs`

## Requirements
- R1: After a synchronous active-low reset, every result register, the most-recent-result register, every flag and the enable mask are zero, so all channels start disabled.
- R2: Each bit of `en_set` enables the matching channel and each bit of `en_clr` disables it, taking effect at the next clock edge. If both bits are high for one channel, the disable wins. The mask reads back at address NCH+2 in bits [NCH-1:0].
- R3: An event (`conv_done` high) on an enabled channel x stores `conv_data` into the result register of x (read address x) and into the most-recent-result register (read address NCH). Both are readable from the next cycle on.
- R4: An event on a disabled channel is ignored completely. No register stores data and no flag changes.
- R5: The completion flag of x (status bit x) is set by an accepted event on x and cleared by a read of address x. When both happen in the same cycle, the flag is set.
- R6: Data-ready (status bit 2·NCH) is set by any accepted event and cleared only by a read of address NCH. A read of a channel result register does not clear it. A read of address NCH that coincides with an ignored event clears it. A channel read that coincides with an accepted event on another channel still sets it.
- R7: The global overrun flag (status bit 2·NCH+1) is set when an event is accepted while data-ready is already high. This includes a cycle in which a channel result register is read.
- R8: The overrun flag of channel x (status bit NCH+x) is set when an event on x is accepted while the completion flag of x is high.
- R9: A read of the status register (address NCH+1) clears the per-channel and global overrun flags. A new overrun in that same cycle keeps the affected flag set.
- R10: The enable mask is sampled before same-cycle mask writes. An event coincides with a disable, even a disable of its own channel, is therefore still accepted, with its data stored and data-ready raised.
- R11: `rd_data` is combinational and shows the register state from before the same-cycle update. Unused addresses (NCH+3 and above) read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_done | input | 1 | End-of-conversion event pulse |
| conv_chan | input | $clog2(NCH) | Channel of the event |
| conv_data | input | RES_W | Conversion result |
| en_set | input | NCH | Per-channel enable pulses |
| en_clr | input | NCH | Per-channel disable pulses |
| rd_en | input | 1 | Read strobe, enables clear side effects |
| rd_addr | input | $clog2(NCH+3) | Read address |
| rd_data | output | 2·NCH+2 | Read value, combinational |

## Verification
Every stored value and flag change appears one clock edge after the cycle holding its stimulus. Read data is due in that same cycle, before the edge. The bench drives each operation just after a rising edge. It samples `rd_data` one settle delay later, before the next edge. It then checks the resulting state by reading in the following cycle. Collision tests place the event, the read and the mask write in one cycle. Each check compares both the pre-update value returned in that cycle and the merged state read afterwards.

// File: rtl/adc_flag_pkg.sv
// Package: shared read-select encoding for the ADC status register block.
// Assumes the address map: channels 0..nch-1, last result nch,
// status nch+1, enable mask nch+2, anything else unmapped.
package adc_flag_pkg;

    typedef enum logic [2:0] {
        SEL_NONE = 3'd0,
        SEL_CHAN = 3'd1,
        SEL_LAST = 3'd2,
        SEL_STAT = 3'd3,
        SEL_MASK = 3'd4
    } rd_sel_e;

    // Map a read address to the register group it selects.
    function automatic rd_sel_e classify(input logic [31:0] addr, input int nch);
        rd_sel_e s;
        if (addr < 32'(nch))            s = SEL_CHAN;
        else if (addr == 32'(nch))      s = SEL_LAST;
        else if (addr == 32'(nch + 1))  s = SEL_STAT;
        else if (addr == 32'(nch + 2))  s = SEL_MASK;
        else                            s = SEL_NONE;
        return s;
    endfunction

endpackage

// File: rtl/adc_evt_decode.sv
// Module: adc_evt_decode
// Turns the raw event and read inputs into one-hot strobes for this cycle.
// Assumes en_mask is the registered mask from before any same-cycle write.
module adc_evt_decode
    import adc_flag_pkg::*;
#(
    parameter int NCH = 8,
    parameter int CW  = 3,
    parameter int AW  = 4
) (
    input  logic           conv_done,
    input  logic [CW-1:0]  conv_chan,
    input  logic [NCH-1:0] en_mask,
    input  logic           rd_en,
    input  logic [AW-1:0]  rd_addr,
    output logic [NCH-1:0] acc_vec,
    output logic [NCH-1:0] rd_chan_vec,
    output logic           rd_last,
    output logic           rd_stat,
    output rd_sel_e        rd_sel
);

    // Classify the read address once for both the mux and the side effects.
    always_comb rd_sel = classify(32'(rd_addr), NCH);

    // Global read strobes that carry clear side effects.
    always_comb begin
        rd_last = rd_en && (rd_sel == SEL_LAST);
        rd_stat = rd_en && (rd_sel == SEL_STAT);
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        // Accepted event on channel i, gated by the pre-update enable.
        always_comb acc_vec[i] = conv_done && (conv_chan == CW'(i)) && en_mask[i];
        // Read of channel i result register.
        always_comb rd_chan_vec[i] = rd_en && (rd_sel == SEL_CHAN) && (rd_addr == AW'(i));
    end

endmodule

// File: rtl/adc_enable_mask.sv
// Module: adc_enable_mask
// Holds the per-channel enable bits; a disable beats an enable on one bit.
// Assumes set and clear vectors are single-cycle pulses.
module adc_enable_mask #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] en_set,
    input  logic [NCH-1:0] en_clr,
    output logic [NCH-1:0] en_mask
);

    // Apply set then clear so that clear has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) en_mask <= '0;
        else        en_mask <= (en_mask | en_set) & ~en_clr;
    end

endmodule

// File: rtl/adc_result_bank.sv
// Module: adc_result_bank
// Stores accepted results per channel and in the shared last-result register.
// Assumes acc_vec is one-hot or zero.
module adc_result_bank #(
    parameter int NCH   = 8,
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   acc_vec,
    input  logic [RES_W-1:0] conv_data,
    output logic [RES_W-1:0] chan_res [NCH],
    output logic [RES_W-1:0] last_res
);

    for (genvar i = 0; i < NCH; i++) begin : g_res
        // Capture the result for channel i on its accepted event.
        always_ff @(posedge clk) begin
            if (!rst_n)          chan_res[i] <= '0;
            else if (acc_vec[i]) chan_res[i] <= conv_data;
        end
    end

    // Capture every accepted result in the shared register.
    always_ff @(posedge clk) begin
        if (!rst_n)        last_res <= '0;
        else if (|acc_vec) last_res <= conv_data;
    end

endmodule

// File: rtl/adc_flag_merge.sv
// Module: adc_flag_merge
// Merges same-cycle sets and clears of all status flags; a set always wins.
// Assumes strobes come from adc_evt_decode for the current cycle.
module adc_flag_merge #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] acc_vec,
    input  logic [NCH-1:0] rd_chan_vec,
    input  logic           rd_last,
    input  logic           rd_stat,
    output logic [NCH-1:0] eoc,
    output logic [NCH-1:0] ovre,
    output logic           drdy,
    output logic           govre
);

    logic any_acc;
    logic govre_new;

    // Any accepted event this cycle, and whether it overruns data-ready.
    always_comb begin
        any_acc   = |acc_vec;
        govre_new = any_acc && drdy;
    end

    for (genvar i = 0; i < NCH; i++) begin : g_flag
        logic ovre_new;
        // Channel overrun: a new result lands while the old one is unread.
        always_comb ovre_new = acc_vec[i] && eoc[i];

        // Completion flag: set by event, cleared by own result read.
        always_ff @(posedge clk) begin
            if (!rst_n)              eoc[i] <= 1'b0;
            else if (acc_vec[i])     eoc[i] <= 1'b1;
            else if (rd_chan_vec[i]) eoc[i] <= 1'b0;
        end

        // Channel overrun flag: set by new overrun, cleared by status read.
        always_ff @(posedge clk) begin
            if (!rst_n)        ovre[i] <= 1'b0;
            else if (ovre_new) ovre[i] <= 1'b1;
            else if (rd_stat)  ovre[i] <= 1'b0;
        end
    end

    // Data-ready: set by any accepted event, cleared by last-result read.
    always_ff @(posedge clk) begin
        if (!rst_n)       drdy <= 1'b0;
        else if (any_acc) drdy <= 1'b1;
        else if (rd_last) drdy <= 1'b0;
    end

    // Global overrun: set by overrun of data-ready, cleared by status read.
    always_ff @(posedge clk) begin
        if (!rst_n)         govre <= 1'b0;
        else if (govre_new) govre <= 1'b1;
        else if (rd_stat)   govre <= 1'b0;
    end

endmodule

// File: rtl/adc_status_regs.sv
// Module: adc_status_regs (top)
// Result and status register bank of a multi-channel ADC with a
// combinational read port whose side effects land at the next edge.
// Assumes RES_W and NCH both fit in the 2*NCH+2 bit read word.
module adc_status_regs
    import adc_flag_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int RES_W = 10
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      conv_done,
    input  logic [$clog2(NCH)-1:0]    conv_chan,
    input  logic [RES_W-1:0]          conv_data,
    input  logic [NCH-1:0]            en_set,
    input  logic [NCH-1:0]            en_clr,
    input  logic                      rd_en,
    input  logic [$clog2(NCH+3)-1:0]  rd_addr,
    output logic [2*NCH+1:0]          rd_data
);

    localparam int CW = $clog2(NCH);
    localparam int AW = $clog2(NCH + 3);
    localparam int DW = 2 * NCH + 2;

    logic [NCH-1:0]   en_mask;
    logic [NCH-1:0]   acc_vec;
    logic [NCH-1:0]   rd_chan_vec;
    logic             rd_last;
    logic             rd_stat;
    rd_sel_e          rd_sel;
    logic [RES_W-1:0] chan_res [NCH];
    logic [RES_W-1:0] last_res;
    logic [NCH-1:0]   eoc;
    logic [NCH-1:0]   ovre;
    logic             drdy;
    logic             govre;
    logic [CW-1:0]    rd_chan;

    adc_enable_mask #(.NCH(NCH)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_set  (en_set),
        .en_clr  (en_clr),
        .en_mask (en_mask)
    );

    adc_evt_decode #(.NCH(NCH), .CW(CW), .AW(AW)) u_dec (
        .conv_done   (conv_done),
        .conv_chan   (conv_chan),
        .en_mask     (en_mask),
        .rd_en       (rd_en),
        .rd_addr     (rd_addr),
        .acc_vec     (acc_vec),
        .rd_chan_vec (rd_chan_vec),
        .rd_last     (rd_last),
        .rd_stat     (rd_stat),
        .rd_sel      (rd_sel)
    );

    adc_result_bank #(.NCH(NCH), .RES_W(RES_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_vec   (acc_vec),
        .conv_data (conv_data),
        .chan_res  (chan_res),
        .last_res  (last_res)
    );

    adc_flag_merge #(.NCH(NCH)) u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_vec     (acc_vec),
        .rd_chan_vec (rd_chan_vec),
        .rd_last     (rd_last),
        .rd_stat     (rd_stat),
        .eoc         (eoc),
        .ovre        (ovre),
        .drdy        (drdy),
        .govre       (govre)
    );

    // Channel index taken from the low address bits.
    always_comb rd_chan = rd_addr[CW-1:0];

    // Read mux over the pre-update register state.
    always_comb begin
        case (rd_sel)
            SEL_CHAN: rd_data = DW'(chan_res[rd_chan]);
            SEL_LAST: rd_data = DW'(last_res);
            SEL_STAT: rd_data = {govre, drdy, ovre, eoc};
            SEL_MASK: rd_data = DW'(en_mask);
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/adc_status_regs_chk.sv
// Module: adc_status_regs_chk
// Temporal checks on the status register block, bound into every instance.
// Assumes it sees the registered mask, flags and last result of the top.
module adc_status_regs_chk #(
    parameter int NCH   = 8,
    parameter int RES_W = 10
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   conv_done,
    input logic [$clog2(NCH)-1:0] conv_chan,
    input logic [RES_W-1:0]       conv_data,
    input logic                   rd_en,
    input logic [NCH-1:0]         en_mask,
    input logic [NCH-1:0]         eoc,
    input logic [NCH-1:0]         ovre,
    input logic                   drdy,
    input logic                   govre,
    input logic [RES_W-1:0]       last_res
);

    logic taken;
    logic dropped;

    // Event classification as seen at the ports and the mask register.
    always_comb begin
        taken   = conv_done && en_mask[conv_chan];
        dropped = conv_done && !en_mask[conv_chan];
    end

    AST_LAST_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        taken |=> last_res == $past(conv_data)); // R3
    AST_DROP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        dropped && !rd_en |=> $stable(eoc) && $stable(ovre) && $stable(drdy)
                              && $stable(govre) && $stable(last_res)); // R4
    AST_EOC_SET: assert property (@(posedge clk) disable iff (!rst_n)
        taken |=> eoc[$past(conv_chan)]); // R5
    AST_DRDY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        taken |=> drdy); // R6
    AST_GOVRE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        taken && drdy |=> govre); // R7
    AST_OVRE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        taken && eoc[conv_chan] |=> ovre[$past(conv_chan)]); // R8
    AST_DRDY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        drdy && !rd_en |=> drdy); // R6

endmodule

bind adc_status_regs adc_status_regs_chk #(.NCH(NCH), .RES_W(RES_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .conv_done (conv_done),
    .conv_chan (conv_chan),
    .conv_data (conv_data),
    .rd_en     (rd_en),
    .en_mask   (en_mask),
    .eoc       (eoc),
    .ovre      (ovre),
    .drdy      (drdy),
    .govre     (govre),
    .last_res  (last_res)
);

// File: tb/sim_adc_status_regs.sv
`timescale 1ns/1ps
module sim_adc_status_regs;

    localparam int NCH    = 8;
    localparam int RES_W  = 10;
    localparam int A_LAST = 8;
    localparam int A_STAT = 9;
    localparam int A_MASK = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_done = 1'b0;
    logic [2:0]  conv_chan = '0;
    logic [9:0]  conv_data = '0;
    logic [7:0]  en_set = '0;
    logic [7:0]  en_clr = '0;
    logic        rd_en = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic [17:0] rd_data;

    int checks = 0;
    int errors = 0;
    logic [17:0] v;

    adc_status_regs #(.NCH(NCH), .RES_W(RES_W)) u0 (
        .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_chan(conv_chan),
        .conv_data(conv_data), .en_set(en_set), .en_clr(en_clr),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always #4 clk = ~clk;

    // Compare one value and report a mismatch.
    task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One cycle with any mix of event, mask write and read; returns rd_data.
    task automatic op(input logic cd, input int ch, input int dat, input int set,
                      input int clr, input logic re, input int addr,
                      output logic [17:0] val);
        conv_done = cd; conv_chan = 3'(ch); conv_data = 10'(dat);
        en_set = 8'(set); en_clr = 8'(clr); rd_en = re; rd_addr = 4'(addr);
        #1 val = rd_data;
        @(posedge clk); #1;
        conv_done = 1'b0; en_set = '0; en_clr = '0; rd_en = 1'b0;
    endtask

    task automatic conv(input int ch, input int dat);
        logic [17:0] d;
        op(1'b1, ch, dat, 0, 0, 1'b0, 0, d);
    endtask

    task automatic rd(input int addr, output logic [17:0] val);
        op(1'b0, 0, 0, 0, 0, 1'b1, addr, val);
    endtask

    task automatic t_reset();
        rd(A_STAT, v); chk("R1 status", v, 18'h0);
        rd(A_LAST, v); chk("R1 last", v, 18'h0);
        rd(A_MASK, v); chk("R1 mask", v, 18'h0);
        rd(0, v);      chk("R1 chan0", v, 18'h0);
    endtask

    task automatic t_enable();
        op(1'b0, 0, 0, 'hA5, 0, 1'b0, 0, v);
        rd(A_MASK, v); chk("R2 set", v, 18'h0A5);
        op(1'b0, 0, 0, 'h0F, 'h05, 1'b0, 0, v);
        rd(A_MASK, v); chk("R2 clear wins", v, 18'h0AA);
        op(1'b0, 0, 0, 'hFF, 0, 1'b0, 0, v);
    endtask

    task automatic t_store();
        conv(3, 'h155);
        rd(A_STAT, v); chk("R5 R6 flags after event", v, 18'h10008);
        rd(3, v);      chk("R3 chan3", v, 18'h155);
        rd(A_LAST, v); chk("R3 last", v, 18'h155);
        rd(A_STAT, v); chk("R5 R6 cleared by reads", v, 18'h0);
    endtask

    task automatic t_disabled();
        op(1'b0, 0, 0, 0, 'h20, 1'b0, 0, v);
        conv(5, 'h2AA);
        rd(A_STAT, v); chk("R4 no flags", v, 18'h0);
        rd(5, v);      chk("R4 chan5 kept", v, 18'h0);
        rd(A_LAST, v); chk("R4 last kept", v, 18'h155);
    endtask

    task automatic t_eoc_collide();
        conv(2, 'h011);
        op(1'b1, 2, 'h022, 0, 0, 1'b1, 2, v);
        chk("R11 pre-update read", v, 18'h011);
        rd(A_STAT, v); chk("R5 R7 R8 set wins", v, 18'h30404);
        rd(2, v);      chk("R3 chan2 new", v, 18'h022);
        rd(A_LAST, v); chk("R3 last new", v, 18'h022);
        rd(A_STAT, v); chk("R9 overruns cleared", v, 18'h0);
    endtask

    task automatic t_last_vs_disabled();
        conv(1, 'h007);
        op(1'b1, 5, 'h3FF, 0, 0, 1'b1, A_LAST, v);
        chk("R11 last read", v, 18'h007);
        rd(A_STAT, v); chk("R6 drdy cleared", v, 18'h00002);
        rd(A_LAST, v); chk("R4 last not stored", v, 18'h007);
        rd(1, v);
    endtask

    task automatic t_chan_read_vs_event();
        conv(0, 'h100);
        rd(A_LAST, v);
        op(1'b1, 6, 'h0AB, 0, 0, 1'b1, 0, v);
        chk("R11 chan0 read", v, 18'h100);
        rd(A_STAT, v); chk("R6 drdy set during chan read", v, 18'h10040);
        rd(6, v);      chk("R3 chan6", v, 18'h0AB);
        rd(A_LAST, v);
        conv(4, 'h044);
        op(1'b1, 4, 'h055, 0, 0, 1'b1, 7, v);
        rd(A_STAT, v); chk("R7 R8 overrun during chan read", v, 18'h31010);
        rd(4, v);      chk("R3 chan4", v, 18'h055);
        rd(A_LAST, v);
        rd(A_STAT, v); chk("R6 R9 clean", v, 18'h0);
    endtask

    task automatic t_disable_collide();
        op(1'b1, 3, 'h0AB, 0, 'h80, 1'b0, 0, v);
        rd(A_STAT, v); chk("R10 drdy with other disable", v, 18'h10008);
        op(1'b1, 6, 'h0CD, 0, 'h40, 1'b0, 0, v);
        rd(A_STAT, v); chk("R10 own disable still accepted", v, 18'h30048);
        rd(A_MASK, v); chk("R2 mask after disables", v, 18'h01F);
        rd(6, v);      chk("R10 chan6 stored", v, 18'h0CD);
        rd(3, v);      chk("R10 chan3 stored", v, 18'h0AB);
        rd(A_LAST, v); chk("R10 last", v, 18'h0CD);
        rd(A_STAT, v); chk("R9 clean", v, 18'h0);
    endtask

    task automatic t_status_collide();
        conv(0, 'h001);
        conv(1, 'h002);
        op(1'b1, 2, 'h003, 0, 0, 1'b1, A_STAT, v);
        chk("R11 status pre-update", v, 18'h30003);
        rd(A_STAT, v); chk("R9 new overrun beats clear", v, 18'h30007);
        rd(A_STAT, v); chk("R9 cleared after", v, 18'h10007);
        op(1'b1, 0, 'h004, 0, 0, 1'b1, A_STAT, v);
        rd(A_STAT, v); chk("R8 R9 channel overrun kept", v, 18'h30107);
        rd(0, v); rd(1, v); rd(2, v); rd(A_LAST, v);
        rd(A_STAT, v); chk("R9 clean", v, 18'h0);
    endtask

    task automatic t_bad_addr();
        rd(15, v); chk("R11 unmapped zero", v, 18'h0);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_enable();
        t_store();
        t_disabled();
        t_eoc_collide();
        t_last_vs_disabled();
        t_chan_read_vs_event();
        t_disable_collide();
        t_status_collide();
        t_bad_addr();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule